// File: doc/BRIEF.md
# Configurable Output Macrocell

This block is one output cell of a sum-of-products programmable logic device. It receives a single sum term from the logic array and turns it into the value of one bidirectional device pin and into one feedback line back into the array. A two-bit configuration code chooses whether the sum term is stored in a D flip-flop or bypasses it, and whether the pin carries the value true or inverted.

The flip-flop has a clear term and a preset term. Both are driven by their own array products. The clear term acts at once, without waiting for a clock edge. The preset term acts only at the next rising clock edge. The pin is driven only while the output-enable term is high. When that term is low the pin floats, so in bypass mode the pin can serve as an input through the feedback line.

The configuration code `{cfg_bypass, cfg_polarity}` is decoded into four named modes: `MODE_REG_LO`, `MODE_REG_HI`, `MODE_COMB_LO` and `MODE_COMB_HI`. The storage element has two states, `ST_ZERO` and `ST_ONE`. Its transitions are:
- clear: any state goes to `ST_ZERO`, asynchronously.
- preset: goes to `ST_ONE` on a rising edge.
- load: on a rising edge with no preset, takes the value of the sum term.

Top module: `macro_cell`

## Requirements
- R1: The code `{cfg_bypass, cfg_polarity}` selects the mode: 00 registered with inverted pin, 01 registered with true pin, 10 bypass with inverted pin, 11 bypass with true pin. A bit value of 1 means programmed.
- R2: On each rising edge of `clk` with `set_term` low and `clr_term` low, the register takes the value of `sum_term`.
- R3: While `clr_term` is high, the register is 0 at once, without a clock edge. This holds even when `set_term` is high at a clock edge.
- R4: With `clr_term` low, `set_term` high at a rising edge makes the register 1 after that edge, whatever the value of `sum_term`.
- R5: In bypass modes (`cfg_bypass`=1), the driven pin value follows `sum_term` combinationally, and the register plays no part.
- R6: With `cfg_polarity`=0 the driven pin value is the inverse of the selected source. With `cfg_polarity`=1 it equals the source.
- R7: In registered modes (`cfg_bypass`=0), `fb` equals the register output, not inverted, whatever `cfg_polarity` is and whatever is on the pin.
- R8: In bypass modes, `fb` equals the value present on `io_pin`.
- R9: While `oe_term` is low the cell does not drive `io_pin`, so a value driven from outside is seen on the pin. In bypass mode that value reaches `fb`.
- R10: After a clear, a registered mode with inverted pin (code 00) drives `io_pin` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Global clock, rising edge active |
| clr_term | input | 1 | Asynchronous clear product, active high |
| set_term | input | 1 | Synchronous preset product, active high |
| sum_term | input | 1 | Sum term from the logic array |
| oe_term | input | 1 | Output-enable product, high drives the pin |
| cfg_bypass | input | 1 | Configuration bit: 1 bypasses the register |
| cfg_polarity | input | 1 | Configuration bit: 1 gives a true pin value, 0 inverted |
| io_pin | inout | 1 | Bidirectional device pin |
| fb | output | 1 | Feedback into the logic array |

## Verification
The assertions watch on every clock edge that the register loads the sum term, that the preset lands one edge later, and that the register stays at 0 while the clear term is high. They also check that the driven pin value matches the selected source with the chosen polarity, and that the registered feedback tracks the register. Some behaviours can only be shown by the bench's scenarios:
- the clear acting between clock edges;
- the clear beating a simultaneous preset;
- an external driver taking over the pin while output enable is low, and that value reaching the feedback only in bypass mode;
- the pin level right after a clear.

The bench sweeps all four codes against every combination of sum term and preset.

// File: rtl/macro_cell_pkg.sv
package macro_cell_pkg;

    // Mode code: {bypass bit, polarity bit}; 1 = programmed
    typedef enum logic [1:0] {
        MODE_REG_LO  = 2'b00,
        MODE_REG_HI  = 2'b01,
        MODE_COMB_LO = 2'b10,
        MODE_COMB_HI = 2'b11
    } cell_mode_e;

    typedef enum logic {
        ST_ZERO = 1'b0,
        ST_ONE  = 1'b1
    } store_state_e;

endpackage

// File: rtl/mc_store.sv
module mc_store
    import macro_cell_pkg::*;
(
    input  logic clk,
    input  logic clr_term,
    input  logic set_term,
    input  logic d_in,
    output logic q_out
);

    store_state_e state_q;
    store_state_e state_d;

    always_comb begin
        if (set_term) begin
            state_d = ST_ONE;
        end else begin
            state_d = d_in ? ST_ONE : ST_ZERO;
        end
    end

    always_ff @(posedge clk or posedge clr_term) begin
        if (clr_term) begin
            state_q <= ST_ZERO;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        unique case (state_q)
            ST_ZERO: q_out = 1'b0;
            ST_ONE:  q_out = 1'b1;
            default: q_out = 1'b0;
        endcase
    end

    // R4: preset lands one edge later
    p_preset_r4: assert property (@(posedge clk) disable iff (clr_term)
        set_term |=> q_out);

    // R2: load of the sum term
    p_load_r2: assert property (@(posedge clk) disable iff (clr_term)
        !set_term |=> (q_out == $past(d_in)));

    // R3: clear holds the register at zero, checked between edges
    always @(negedge clk) begin
        if (clr_term) begin
            p_clear_r3: assert (q_out == 1'b0);
        end
    end

endmodule

// File: rtl/mc_route.sv
module mc_route
    import macro_cell_pkg::*;
(
    input  cell_mode_e mode,
    input  logic       sum_in,
    input  logic       q_in,
    input  logic       pin_in,
    output logic       drive_val,
    output logic       fb_out
);

    logic src;

    always_comb begin
        unique case (mode)
            MODE_REG_LO: begin
                src       = q_in;
                drive_val = ~src;
                fb_out    = q_in;
            end
            MODE_REG_HI: begin
                src       = q_in;
                drive_val = src;
                fb_out    = q_in;
            end
            MODE_COMB_LO: begin
                src       = sum_in;
                drive_val = ~src;
                fb_out    = pin_in;
            end
            MODE_COMB_HI: begin
                src       = sum_in;
                drive_val = src;
                fb_out    = pin_in;
            end
            default: begin
                src       = q_in;
                drive_val = ~src;
                fb_out    = q_in;
            end
        endcase
    end

endmodule

// File: rtl/macro_cell.sv
module macro_cell
    import macro_cell_pkg::*;
(
    input  logic clk,
    input  logic clr_term,
    input  logic set_term,
    input  logic sum_term,
    input  logic oe_term,
    input  logic cfg_bypass,
    input  logic cfg_polarity,
    inout  wire  io_pin,
    output logic fb
);

    cell_mode_e mode;
    logic       q_w;
    logic       drive_w;

    assign mode = cell_mode_e'({cfg_bypass, cfg_polarity});

    mc_store u_store (
        .clk      (clk),
        .clr_term (clr_term),
        .set_term (set_term),
        .d_in     (sum_term),
        .q_out    (q_w)
    );

    mc_route u_route (
        .mode      (mode),
        .sum_in    (sum_term),
        .q_in      (q_w),
        .pin_in    (io_pin),
        .drive_val (drive_w),
        .fb_out    (fb)
    );

    assign io_pin = oe_term ? drive_w : 1'bz;

    // R5 / R6: bypass drive value against the sum term and polarity bit
    p_bypass_drive_r5: assert property (@(posedge clk) disable iff (clr_term)
        cfg_bypass |-> (drive_w == (sum_term ~^ cfg_polarity)));

    // R1 / R6: registered drive value against the register and polarity bit
    p_reg_drive_r6: assert property (@(posedge clk) disable iff (clr_term)
        !cfg_bypass |-> (drive_w == (q_w ~^ cfg_polarity)));

    // R7: registered feedback shows last loaded sum term
    p_reg_fb_r7: assert property (@(posedge clk) disable iff (clr_term)
        (!set_term && !cfg_bypass) |=> (cfg_bypass || fb == $past(sum_term)));

endmodule

// File: tb/macro_cell_test.sv
module macro_cell_test;

    localparam int PERIOD = 10;

    logic clk = 1'b0;
    logic clr_term, set_term, sum_term, oe_term, cfg_bypass, cfg_polarity;
    logic ext_en, ext_val;
    wire  pin_w;
    logic fb;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    assign pin_w = ext_en ? ext_val : 1'bz;

    always #(PERIOD/2) clk = ~clk;

    macro_cell uut (
        .clk          (clk),
        .clr_term     (clr_term),
        .set_term     (set_term),
        .sum_term     (sum_term),
        .oe_term      (oe_term),
        .cfg_bypass   (cfg_bypass),
        .cfg_polarity (cfg_polarity),
        .io_pin       (pin_w),
        .fb           (fb)
    );

    task automatic check(input string req, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic drive_slot();
        @(negedge clk);
        #1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        #(PERIOD * 5000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=1 expected=0");
        finish_run();
    end

    initial begin
        clr_term = 1'b1; set_term = 1'b0; sum_term = 1'b0; oe_term = 1'b1;
        cfg_bypass = 1'b0; cfg_polarity = 1'b0; ext_en = 1'b0; ext_val = 1'b0;
        repeat (2) @(posedge clk);
        drive_slot();
        // R10: cleared register, code 00, pin high; R7 feedback low
        check("R10 pin after clear", pin_w, 1'b1);
        check("R7 fb after clear", fb, 1'b0);
        clr_term = 1'b0;

        // R1 R2 R4 R5 R6 R7 R8: sweep codes, sum, preset
        for (int code = 0; code < 4; code++) begin
            for (int s = 0; s < 2; s++) begin
                for (int p = 0; p < 2; p++) begin
                    drive_slot();
                    cfg_bypass   = code[1];
                    cfg_polarity = code[0];
                    sum_term     = s[0];
                    set_term     = p[0];
                    @(posedge clk);
                    #2;
                    begin
                        logic qexp, pexp;
                        qexp = p[0] ? 1'b1 : s[0];
                        if (!code[1]) begin
                            pexp = qexp ^ ~code[0];
                            check(p[0] ? "R4 preset pin" : "R2 load pin", pin_w, pexp);
                            check("R7 registered fb", fb, qexp);
                        end else begin
                            pexp = s[0] ^ ~code[0];
                            check("R5 R6 bypass pin", pin_w, pexp);
                            check("R8 bypass fb", fb, pexp);
                        end
                    end
                end
            end
        end
        set_term = 1'b0;

        // R5 R6: bypass inverted, changes without a clock edge
        drive_slot();
        cfg_bypass = 1'b1; cfg_polarity = 1'b0; sum_term = 1'b1;
        #1 check("R6 bypass inverted", pin_w, 1'b0);
        sum_term = 1'b0;
        #1 check("R5 bypass follows sum", pin_w, 1'b1);

        // R3: clear between edges, then beats preset at an edge
        drive_slot();
        cfg_bypass = 1'b0; cfg_polarity = 1'b1; set_term = 1'b1;
        @(posedge clk);
        #2 check("R4 preset before clear", fb, 1'b1);
        clr_term = 1'b1;
        #1 check("R3 async clear", fb, 1'b0);
        @(posedge clk);
        #2 check("R3 clear beats preset", fb, 1'b0);
        drive_slot();
        clr_term = 1'b0; set_term = 1'b0; sum_term = 1'b1;
        @(posedge clk);
        #2 check("R2 load after clear", fb, 1'b1);

        // R9 R8: output disabled, external value reaches fb in bypass
        drive_slot();
        oe_term = 1'b0; ext_en = 1'b1;
        cfg_bypass = 1'b1; cfg_polarity = 1'b1; sum_term = 1'b1;
        ext_val = 1'b0;
        #1 check("R9 bypass ext low", fb, 1'b0);
        ext_val = 1'b1; sum_term = 1'b0;
        #1 check("R9 bypass ext high", fb, 1'b1);

        // R9 R7: registered mode, pin taken over, fb still register
        drive_slot();
        cfg_bypass = 1'b0; cfg_polarity = 1'b0; sum_term = 1'b1;
        @(posedge clk);
        #2;
        ext_val = 1'b1;
        #1 check("R9 ext drives pin", pin_w, 1'b1);
        check("R7 fb ignores pin", fb, 1'b1);
        ext_val = 1'b0;
        #1 check("R7 fb ignores pin low", fb, 1'b1);

        drive_slot();
        finish_run();
    end

endmodule